// File: doc/BRIEF.md
# Pin Controller with Set/Clear Output Registers

This block is a register-mapped general-purpose pin controller for either 16 or 20 pins. The `NPINS` parameter sets the pin count. Software reaches it over a plain 64-bit register port made of an address, a write strobe, write data, a read strobe and registered read data. Output levels change only through two write-one-acting registers. One forces bits high and the other forces bits low. Each pin has its own direction register, and its bit 0 turns the output driver on.

Each bus cycle is decoded into one access kind: NONE (unmapped, misaligned or out of range), LEVEL (input sample read), SET (raise outputs), CLR (lower outputs) or CFG (per-pin direction register). The output latch and the direction bits act on that kind in the clock edge where `wr_en` is sampled. The read path registers the value the kind selects. Pin inputs pass through two flops before software can read them.

A typical sequence loads the wanted level through SET or CLR first and then sets the pin's direction bit. The pin then drives the intended level from its first enabled cycle.

Top module: `gpio_setclr`

## Requirements
- R1: While `rst_n` is low, `pin_out`, `pin_oe` and `rd_data` are all zero, so every pin is an input that holds a low latch value.
- R2: A read at byte offset 0x80 returns the synchronized level of pin n in bit n. Bits at positions `NPINS` and above read as zero.
- R3: A write at offset 0x88 sets to 1 each output latch bit whose write-data bit is 1. Latch bits whose write-data bit is 0 keep their value. The change shows on `pin_out` after that clock edge.
- R4: A write at offset 0x90 clears to 0 each output latch bit whose write-data bit is 1. Latch bits whose write-data bit is 0 keep their value.
- R5: The direction register for pin p with p < 16 is at offset 8*p. A write stores write-data bit 0 as that pin's output enable, which appears on `pin_oe[p]`. Writing zero returns the pin to input mode. A read returns the enable in bit 0 with all other bits zero.
- R6: The direction register for pin p with p >= 16 is at offset 0x100 + 8*(p-16). It behaves exactly as in R5.
- R7: `pin_out` always carries the latch value, whatever the enable is. A level loaded before the enable is set is therefore present on `pin_out` in the first cycle that `pin_oe` is 1.
- R8: An access to any other offset has no side effect and reads zero. This covers offsets not a multiple of 8, direction slots of pins beyond `NPINS`, and the range 0x98 to 0xFF. The SET and CLR registers also read zero, and a write to 0x80 has no effect.
- R9: `rd_data` is the value selected by `rd_en` and `addr` at the previous rising edge. It is zero after any edge at which `rd_en` was low.
- R10: A change on `pin_in` made between edges k-1 and k first appears in a LEVEL read whose `rd_en` is sampled at edge k+2. Reads sampled at edges k and k+1 still return the old level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (12) | Byte offset of the access |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Read strobe, sampled at the rising edge |
| rd_data | output | 64 | Registered read data |
| pin_in | input | NPINS (20) | Pin input levels, asynchronous |
| pin_out | output | NPINS (20) | Output latch value for each pin |
| pin_oe | output | NPINS (20) | Output enable for each pin |

## Verification
Writes take effect at the edge that samples `wr_en`, so the bench checks `pin_out` and `pin_oe` at the following falling edge. Read data is registered and is checked at the falling edge after the read strobe. Input changes need two extra edges. The bench checks this by applying a new level and then issuing three back-to-back LEVEL reads, expecting the old value from the first two and the new value from the third. All other reads wait three edges after the last `pin_in` change, so every reference value comes from the bench's arithmetic model of the settled state.

// File: rtl/gpio_setclr_pkg.sv
package gpio_setclr_pkg;

    localparam int unsigned BUS_W       = 64;
    localparam int unsigned BANK_SPLIT  = 16;
    localparam int unsigned OFF_LEVEL   = 'h80;
    localparam int unsigned OFF_SET     = 'h88;
    localparam int unsigned OFF_CLR     = 'h90;
    localparam int unsigned OFF_BANK_HI = 'h100;
    localparam int unsigned CFG_STRIDE  = 8;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_LEVEL,
        ACC_SET,
        ACC_CLR,
        ACC_CFG
    } acc_kind_e;

endpackage

// File: rtl/gpio_setclr_sync.sv
module gpio_setclr_sync #(
    parameter int unsigned NPINS = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] din,
    output logic [NPINS-1:0] dout
);

    logic [NPINS-1:0] stage1;

    for (genvar g = 0; g < NPINS; g++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[g] <= 1'b0;
                dout[g]   <= 1'b0;
            end else begin
                stage1[g] <= din[g];
                dout[g]   <= stage1[g];
            end
        end
    end

endmodule

// File: rtl/gpio_setclr_decode.sv
module gpio_setclr_decode
    import gpio_setclr_pkg::*;
#(
    parameter int unsigned NPINS  = 20,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned PIN_W  = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [PIN_W-1:0]  pin
);

    localparam int unsigned HI_PINS = NPINS - BANK_SPLIT;
    localparam logic [ADDR_W-1:0] A_LEVEL  = ADDR_W'(OFF_LEVEL);
    localparam logic [ADDR_W-1:0] A_SET    = ADDR_W'(OFF_SET);
    localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(OFF_CLR);
    localparam logic [ADDR_W-1:0] A_HI     = ADDR_W'(OFF_BANK_HI);
    localparam logic [ADDR_W-1:0] A_HI_END = ADDR_W'(OFF_BANK_HI + CFG_STRIDE * HI_PINS);

    logic [ADDR_W-1:0] hi_rel;
    logic              unused_lo;

    assign hi_rel    = addr - A_HI;
    assign unused_lo = ^hi_rel[2:0];

    always_comb begin
        kind = ACC_NONE;
        pin  = '0;
        if (addr[2:0] == 3'b000) begin
            if (addr == A_LEVEL) begin
                kind = ACC_LEVEL;
            end else if (addr == A_SET) begin
                kind = ACC_SET;
            end else if (addr == A_CLR) begin
                kind = ACC_CLR;
            end else if (addr < A_LEVEL) begin
                kind = ACC_CFG;
                pin  = PIN_W'(addr[6:3]);
            end else if (addr >= A_HI && addr < A_HI_END) begin
                kind = ACC_CFG;
                pin  = PIN_W'(32'(hi_rel[ADDR_W-1:3]) + BANK_SPLIT);
            end
        end
    end

endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
    import gpio_setclr_pkg::*;
#(
    parameter int unsigned NPINS = 20,
    parameter int unsigned PIN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  acc_kind_e        kind,
    input  logic [PIN_W-1:0] pin,
    input  logic [NPINS-1:0] wr_bits,
    input  logic             cfg_bit,
    output logic [NPINS-1:0] out_q,
    output logic [NPINS-1:0] oe_q
);

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_q[g] <= 1'b0;
                oe_q[g]  <= 1'b0;
            end else if (wr_en) begin
                unique case (kind)
                    ACC_SET: if (wr_bits[g]) out_q[g] <= 1'b1;
                    ACC_CLR: if (wr_bits[g]) out_q[g] <= 1'b0;
                    ACC_CFG: if (pin == PIN_W'(g)) oe_q[g] <= cfg_bit;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/gpio_setclr.sv
module gpio_setclr
    import gpio_setclr_pkg::*;
#(
    parameter int unsigned NPINS  = 20,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [63:0]       wr_data,
    input  logic              rd_en,
    output logic [63:0]       rd_data,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe
);

    localparam int unsigned PIN_W = $clog2(NPINS);

    acc_kind_e          kind;
    logic [PIN_W-1:0]   pin;
    logic [NPINS-1:0]   level;
    logic [BUS_W-1:0]   rd_next;
    logic               unused_hi;

    assign unused_hi = ^wr_data[BUS_W-1:NPINS];

    gpio_setclr_sync #(.NPINS(NPINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (level)
    );

    gpio_setclr_decode #(.NPINS(NPINS), .ADDR_W(ADDR_W), .PIN_W(PIN_W)) u_decode (
        .addr(addr),
        .kind(kind),
        .pin (pin)
    );

    gpio_setclr_bank #(.NPINS(NPINS), .PIN_W(PIN_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .kind   (kind),
        .pin    (pin),
        .wr_bits(wr_data[NPINS-1:0]),
        .cfg_bit(wr_data[0]),
        .out_q  (pin_out),
        .oe_q   (pin_oe)
    );

    always_comb begin
        unique case (kind)
            ACC_LEVEL: rd_next = BUS_W'(level);
            ACC_CFG:   rd_next = BUS_W'(pin_oe[pin]);
            default:   rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_en ? rd_next : '0;
        end
    end

    assert_set_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == ACC_SET) |=>
            ((pin_out & $past(wr_data[NPINS-1:0])) == $past(wr_data[NPINS-1:0])));

    assert_clr_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == ACC_CLR) |=> ((pin_out & $past(wr_data[NPINS-1:0])) == '0));

    assert_cfg_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == ACC_CFG) |=> (pin_oe[$past(pin)] == $past(wr_data[0])));

    assert_cfg_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_CFG) |-> (32'(pin) < NPINS));

    assert_quiet_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_NONE || kind == ACC_LEVEL) |=> ($stable(pin_out) && $stable(pin_oe)));

    assert_cfg_read_narrow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && kind == ACC_CFG) |=> (rd_data[BUS_W-1:1] == '0));

    assert_idle_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == '0));

endmodule

// File: tb/gpio_setclr_bench.sv
`timescale 1ns/1ps
module gpio_setclr_bench;

    localparam int NP = 20;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          wr_en;
    logic [63:0]   wr_data;
    logic          rd_en;
    logic [63:0]   rd_data;
    logic [NP-1:0] pin_in;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [NP-1:0] m_out, m_oe, m_in;

    always #4 clk = ~clk;

    gpio_setclr #(.NPINS(NP), .ADDR_W(AW)) u_gpio_setclr (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input int a, input logic [63:0] d);
        addr = AW'(a); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input int a, output logic [63:0] v);
        addr = AW'(a); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    function automatic int cfg_addr(input int p);
        return (p < 16) ? 8 * p : 'h100 + 8 * (p - 16);
    endfunction

    function automatic logic [63:0] exp_rd(input int a);
        if (a % 8 != 0) return 64'd0;
        if (a == 'h80) return 64'(m_in);
        if (a < 'h80) return 64'(m_oe[a / 8]);
        if (a >= 'h100 && a < 'h100 + 8 * (NP - 16)) return 64'(m_oe[16 + (a - 'h100) / 8]);
        return 64'd0;
    endfunction

    function automatic bit acts_on_write(input int a);
        if (a % 8 != 0) return 1'b0;
        return (a == 'h88) || (a == 'h90) || (a < 'h80) ||
               (a >= 'h100 && a < 'h100 + 8 * (NP - 16));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        logic [63:0] lfsr;
        rst_n = 1'b0; addr = '0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0; pin_in = '0;
        m_out = '0; m_oe = '0; m_in = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(pin_out == '0, "R1 pin_out", 64'(pin_out), 64'd0);
        chk(pin_oe == '0, "R1 pin_oe", 64'(pin_oe), 64'd0);
        chk(rd_data == '0, "R1 rd_data", rd_data, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: set each pin in turn, with upper data bits also set
        for (int p = 0; p < NP; p++) begin
            do_write('h88, (64'd1 << p) | (64'hFFFF_FFFF_FFFF_FFFF << NP));
            m_out[p] = 1'b1;
            chk(pin_out == m_out, "R3 set sweep", 64'(pin_out), 64'(m_out));
        end
        // R4: clear odd pins one at a time
        for (int p = 1; p < NP; p += 2) begin
            do_write('h90, 64'd1 << p);
            m_out[p] = 1'b0;
            chk(pin_out == m_out, "R4 clear sweep", 64'(pin_out), 64'(m_out));
        end
        // R3 R4: pseudo-random mixed patterns
        lfsr = 64'h0123_4567_89AB_CDEF;
        for (int i = 0; i < 40; i++) begin
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            if (i % 2 == 0) begin
                do_write('h88, lfsr);
                m_out = m_out | lfsr[NP-1:0];
                chk(pin_out == m_out, "R3 pattern set", 64'(pin_out), 64'(m_out));
            end else begin
                do_write('h90, lfsr);
                m_out = m_out & ~lfsr[NP-1:0];
                chk(pin_out == m_out, "R4 pattern clear", 64'(pin_out), 64'(m_out));
            end
        end

        // R5 R6: enable even pins with all-ones data, check readback
        for (int p = 0; p < NP; p += 2) begin
            do_write(cfg_addr(p), 64'hFFFF_FFFF_FFFF_FFFF);
            m_oe[p] = 1'b1;
            chk(pin_oe == m_oe, (p < 16) ? "R5 cfg write" : "R6 cfg write", 64'(pin_oe), 64'(m_oe));
        end
        for (int p = 0; p < NP; p++) begin
            do_read(cfg_addr(p), v);
            chk(v == exp_rd(cfg_addr(p)), (p < 16) ? "R5 cfg read" : "R6 cfg read", v, exp_rd(cfg_addr(p)));
        end
        // R5 R6: writing zero returns pins to input mode
        for (int p = 0; p < NP; p += 4) begin
            do_write(cfg_addr(p), 64'd0);
            m_oe[p] = 1'b0;
            chk(pin_oe == m_oe, (p < 16) ? "R5 cfg clear" : "R6 cfg clear", 64'(pin_oe), 64'(m_oe));
        end
        // R9: idle cycle after a nonzero read
        do_read(cfg_addr(2), v);
        @(negedge clk);
        chk(rd_data == '0, "R9 idle read zero", rd_data, 64'd0);

        // R10: exact synchronizer latency
        pin_in = 20'hA5A5A; m_in = pin_in;
        repeat (3) @(negedge clk);
        pin_in = 20'h5A5A5;
        do_read('h80, v);
        chk(v == 64'h0A5A5A, "R10 read at edge k", v, 64'h0A5A5A);
        do_read('h80, v);
        chk(v == 64'h0A5A5A, "R10 read at edge k+1", v, 64'h0A5A5A);
        do_read('h80, v);
        chk(v == 64'h05A5A5, "R10 read at edge k+2", v, 64'h05A5A5);
        m_in = pin_in;
        // R2: level reads for several patterns
        for (int i = 0; i < 6; i++) begin
            pin_in = NP'(32'h9E37_79B9 * (i + 1));
            m_in = pin_in;
            repeat (3) @(negedge clk);
            do_read('h80, v);
            chk(v == 64'(m_in), "R2 level read", v, 64'(m_in));
        end

        // R8 R5 R6 R2: read every offset in the lower range
        for (int a = 0; a < 'h200; a++) begin
            do_read(a, v);
            chk(v == exp_rd(a), "R8 address sweep read", v, exp_rd(a));
        end
        // R8: writes to unmapped offsets and to 0x80 change nothing
        for (int a = 0; a < 'h200; a++) begin
            if (!acts_on_write(a)) begin
                do_write(a, 64'hFFFF_FFFF_FFFF_FFFF);
                chk(pin_out == m_out && pin_oe == m_oe, "R8 unmapped write",
                    {24'd0, pin_oe, pin_out}, {24'd0, m_oe, m_out});
            end
        end

        // R7: preload output level, then enable
        do_write('h90, 64'hFFFF_FFFF_FFFF_FFFF);
        m_out = '0;
        do_write(cfg_addr(5), 64'd0);
        m_oe[5] = 1'b0;
        do_write('h88, 64'd1 << 5);
        m_out[5] = 1'b1;
        chk(pin_out[5] == 1'b1 && pin_oe[5] == 1'b0, "R7 preload before enable",
            {62'd0, pin_oe[5], pin_out[5]}, 64'd1);
        do_write(cfg_addr(5), 64'd1);
        m_oe[5] = 1'b1;
        chk(pin_out[5] == 1'b1 && pin_oe[5] == 1'b1, "R7 first enabled cycle",
            {62'd0, pin_oe[5], pin_out[5]}, 64'd3);
        chk(pin_out == m_out && pin_oe == m_oe, "R7 other pins", {24'd0, pin_oe, pin_out}, {24'd0, m_oe, m_out});

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule